// File: doc/BRIEF.md
# Interruption Return Unit

This unit performs the state-restore step of a return-from-interruption operation in a processor that runs either native code or a legacy 32-bit instruction set. Each request presents the live status word, the status word and instruction pointer saved at interruption time, the legacy code-segment base, a flag telling whether the legacy target is 16-bit code, and the current register-frame marker. The unit checks privilege and virtualization first. If both checks pass, it loads the saved status into the live status and chooses the target mode from the saved instruction-set bit.

For a legacy target the unit rebases the instruction pointer against the segment base and empties the register frame. It also clears four debug and deferral disable bits and flags illegal saved-status combinations. For a 16-bit target whose pointer falls outside the addressable window, it raises a general-protection flag. Restored state and all flags are registered and appear together with a one-cycle done pulse.

Status-word bit layout, MSB first: [11:10] privilege level, [9] virtualization, [8] instruction-set select (1 = legacy), [7] interruption collection, [6] data translation, [5] machine-check mask, [4] instruction translation, [3] data-access disable, [2] data-debug disable, [1] instruction-access disable, [0] exception-deferral disable. The frame marker is six FRM_W-bit fields. From MSB they are: frame size, locals size, rotating size, general rotation base, floating-point rotation base and predicate rotation base.

Top module: `iret_unit`

## Requirements
- R1: A request whose current privilege level (bits [11:10]) is nonzero raises fault_priv with done. live_status, ip_out and frame_out keep their previous values.
- R2: A request with privilege level zero and current virtualization bit [9] set raises fault_virt instead, with no state change. At most one fault flag is ever high.
- R3: A request that passes both checks loads live_status from the saved status. In native mode the load is exact. In legacy mode bits [3:0] are the only ones altered.
- R4: done is high exactly in the cycle after req_valid. fault_priv, fault_virt, undef_flag and gp_fault are low whenever done is low.
- R5: On success with saved bit [8] = 0, ip_out equals saved_ip, frame_out equals frame_in, and undef_flag and gp_fault stay low.
- R6: On success with saved bit [8] = 1, undef_flag is high if the saved status has bit [7] = 0, bit [6] = 0, bit [5] = 1 or bit [4] = 0.
- R7: On a legacy success, ip_out equals (saved_ip[31:0] - seg_base) mod 2^32, zero-extended to IP_W bits.
- R8: On a legacy success, all six frame_out fields are zero.
- R9: On a legacy success with seg16 = 1, gp_fault is high exactly when the rebased 32-bit pointer is not below 2^WIN_W. A pointer below the base wraps and so counts as outside.
- R10: On a legacy success, live_status bits [3:0] are zero, whatever the saved values were.
- R11: After reset, done, all flags, live_status, ip_out and frame_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per return |
| cur_status | input | 12 | Live status word before the return |
| saved_status | input | 12 | Status word saved at interruption |
| saved_ip | input | IP_W | Instruction pointer saved at interruption |
| seg_base | input | 32 | Legacy code-segment base |
| seg16 | input | 1 | Legacy target is 16-bit code |
| frame_in | input | 6*FRM_W | Current register-frame marker |
| done | output | 1 | Result valid pulse |
| fault_priv | output | 1 | Privileged-operation fault |
| fault_virt | output | 1 | Virtualization fault |
| undef_flag | output | 1 | Illegal saved status for legacy entry |
| gp_fault | output | 1 | 16-bit target outside segment window |
| live_status | output | 12 | Restored live status word |
| ip_out | output | IP_W | Target instruction pointer |
| frame_out | output | 6*FRM_W | Restored register-frame marker |

## Verification
The bench builds the unit with IP_W = 36 and WIN_W = 8. The narrow pointer keeps the bits above the low 32 visible, so native pass-through and legacy truncation can be told apart. The 256-byte window lets ordinary pointer offsets cross the general-protection boundary on both sides. Every one of the 4096 saved-status encodings goes through the unit with faulting and non-faulting current status. This covers every combination of the four illegal-status conditions and of the disable bits. Directed cases then probe the window edge, a base near the top of the 32-bit space, and pointers below the base.

// File: rtl/iret_pkg.sv
package iret_pkg;

    localparam int ST_W     = 12;
    localparam int FRM_W    = 7;
    localparam int FRM_FLDS = 6;
    localparam int FRM_TOT  = FRM_W * FRM_FLDS;

    typedef struct packed {
        logic [1:0] priv;
        logic       virt;
        logic       iset;
        logic       icoll;
        logic       dxlat;
        logic       mchk;
        logic       ixlat;
        logic       dacc_off;
        logic       ddbg_off;
        logic       iacc_off;
        logic       xdef_off;
    } stat_t;

    typedef struct packed {
        logic [FRM_W-1:0] size_all;
        logic [FRM_W-1:0] size_loc;
        logic [FRM_W-1:0] size_rot;
        logic [FRM_W-1:0] base_gr;
        logic [FRM_W-1:0] base_fr;
        logic [FRM_W-1:0] base_pr;
    } frame_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PRIV = 2'd1,
        FLT_VIRT = 2'd2
    } fault_e;

    // Legacy entry drops the four disable bits.
    function automatic stat_t strip_disables(stat_t s);
        stat_t r;
        r          = s;
        r.dacc_off = 1'b0;
        r.ddbg_off = 1'b0;
        r.iacc_off = 1'b0;
        r.xdef_off = 1'b0;
        return r;
    endfunction

    // Saved status that cannot legally resume legacy code.
    function automatic logic legacy_illegal(stat_t s);
        return !s.icoll || !s.dxlat || s.mchk || !s.ixlat;
    endfunction

endpackage

// File: rtl/iret_fault_arb.sv
module iret_fault_arb
    import iret_pkg::*;
(
    input  stat_t  cur,
    output fault_e code
);
    always_comb begin
        if (cur.priv != 2'd0)
            code = FLT_PRIV;
        else if (cur.virt)
            code = FLT_VIRT;
        else
            code = FLT_NONE;
    end
endmodule

// File: rtl/iret_legacy_xform.sv
module iret_legacy_xform
    import iret_pkg::*;
#(
    parameter int IP_W  = 64,
    parameter int WIN_W = 16
) (
    input  stat_t            saved,
    input  logic [IP_W-1:0]  saved_ip,
    input  logic [31:0]      seg_base,
    input  logic             seg16,
    input  frame_t           frame_in,
    output stat_t            nxt_stat,
    output logic [IP_W-1:0]  nxt_ip,
    output frame_t           nxt_frame,
    output logic             nxt_undef,
    output logic             nxt_gp
);
    localparam int PAD_W = IP_W - 32;

    logic [31:0] rebased;
    logic        outside;

    assign rebased = saved_ip[31:0] - seg_base;

    generate
        if (WIN_W >= 32) begin : g_nowin
            assign outside = 1'b0;
        end else begin : g_win
            assign outside = |rebased[31:WIN_W];
        end
    endgenerate

    always_comb begin
        if (saved.iset) begin
            nxt_stat  = strip_disables(saved);
            nxt_ip    = {{PAD_W{1'b0}}, rebased};
            nxt_frame = '0;
            nxt_undef = legacy_illegal(saved);
            nxt_gp    = seg16 && outside;
        end else begin
            nxt_stat  = saved;
            nxt_ip    = saved_ip;
            nxt_frame = frame_in;
            nxt_undef = 1'b0;
            nxt_gp    = 1'b0;
        end
    end
endmodule

// File: rtl/iret_unit.sv
module iret_unit
    import iret_pkg::*;
#(
    parameter int IP_W  = 64,
    parameter int WIN_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ST_W-1:0]    cur_status,
    input  logic [ST_W-1:0]    saved_status,
    input  logic [IP_W-1:0]    saved_ip,
    input  logic [31:0]        seg_base,
    input  logic               seg16,
    input  logic [FRM_TOT-1:0] frame_in,
    output logic               done,
    output logic               fault_priv,
    output logic               fault_virt,
    output logic               undef_flag,
    output logic               gp_fault,
    output logic [ST_W-1:0]    live_status,
    output logic [IP_W-1:0]    ip_out,
    output logic [FRM_TOT-1:0] frame_out
);
    fault_e          fcode;
    stat_t           nxt_stat;
    logic [IP_W-1:0] nxt_ip;
    frame_t          nxt_frame;
    logic            nxt_undef;
    logic            nxt_gp;

    iret_fault_arb u_arb (
        .cur  (stat_t'(cur_status)),
        .code (fcode)
    );

    iret_legacy_xform #(
        .IP_W  (IP_W),
        .WIN_W (WIN_W)
    ) u_xform (
        .saved     (stat_t'(saved_status)),
        .saved_ip  (saved_ip),
        .seg_base  (seg_base),
        .seg16     (seg16),
        .frame_in  (frame_t'(frame_in)),
        .nxt_stat  (nxt_stat),
        .nxt_ip    (nxt_ip),
        .nxt_frame (nxt_frame),
        .nxt_undef (nxt_undef),
        .nxt_gp    (nxt_gp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            fault_priv  <= 1'b0;
            fault_virt  <= 1'b0;
            undef_flag  <= 1'b0;
            gp_fault    <= 1'b0;
            live_status <= '0;
            ip_out      <= '0;
            frame_out   <= '0;
        end else begin
            done       <= req_valid;
            fault_priv <= 1'b0;
            fault_virt <= 1'b0;
            undef_flag <= 1'b0;
            gp_fault   <= 1'b0;
            if (req_valid) begin
                case (fcode)
                    FLT_PRIV: fault_priv <= 1'b1;
                    FLT_VIRT: fault_virt <= 1'b1;
                    default: begin
                        live_status <= nxt_stat;
                        ip_out      <= nxt_ip;
                        frame_out   <= nxt_frame;
                        undef_flag  <= nxt_undef;
                        gp_fault    <= nxt_gp;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/iret_unit_chk.sv
module iret_unit_chk
    import iret_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               done,
    input logic               fault_priv,
    input logic               fault_virt,
    input logic               undef_flag,
    input logic               gp_fault,
    input logic [ST_W-1:0]    live_status,
    input logic [FRM_TOT-1:0] frame_out
);
    // R4
    req_done_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);

    // R4
    flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(fault_priv || fault_virt || undef_flag || gp_fault));

    // R2
    one_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_priv, fault_virt}));

    // R1
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (fault_priv || fault_virt)) |->
            (live_status == $past(live_status) && frame_out == $past(frame_out)));

    // R8
    frame_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fault_priv && !fault_virt && live_status[8]) |-> frame_out == '0);

    // R10
    dbg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fault_priv && !fault_virt && live_status[8]) |-> live_status[3:0] == 4'd0);

    // R6
    undef_mode_chk: assert property (@(posedge clk) disable iff (rst)
        undef_flag |-> live_status[8]);

    // R9
    gp_mode_chk: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> live_status[8]);
endmodule

bind iret_unit iret_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .done        (done),
    .fault_priv  (fault_priv),
    .fault_virt  (fault_virt),
    .undef_flag  (undef_flag),
    .gp_fault    (gp_fault),
    .live_status (live_status),
    .frame_out   (frame_out)
);

// File: tb/iret_unit_test.sv
module iret_unit_test;
    import iret_pkg::*;

    localparam int CLK_P = 10;
    localparam int IP_W  = 36;
    localparam int WIN_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [ST_W-1:0]    cur_status = '0;
    logic [ST_W-1:0]    saved_status = '0;
    logic [IP_W-1:0]    saved_ip = '0;
    logic [31:0]        seg_base = '0;
    logic               seg16 = 1'b0;
    logic [FRM_TOT-1:0] frame_in = '0;
    logic               done, fault_priv, fault_virt, undef_flag, gp_fault;
    logic [ST_W-1:0]    live_status;
    logic [IP_W-1:0]    ip_out;
    logic [FRM_TOT-1:0] frame_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [ST_W-1:0]    e_live = '0;
    logic [IP_W-1:0]    e_ip   = '0;
    logic [FRM_TOT-1:0] e_frm  = '0;

    always #(CLK_P/2) clk = ~clk;

    iret_unit #(.IP_W(IP_W), .WIN_W(WIN_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .cur_status(cur_status), .saved_status(saved_status),
        .saved_ip(saved_ip), .seg_base(seg_base), .seg16(seg16),
        .frame_in(frame_in), .done(done), .fault_priv(fault_priv),
        .fault_virt(fault_virt), .undef_flag(undef_flag), .gp_fault(gp_fault),
        .live_status(live_status), .ip_out(ip_out), .frame_out(frame_out)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(logic [ST_W-1:0] cur, logic [ST_W-1:0] sv,
                       logic [IP_W-1:0] ip, logic [31:0] base, logic s16,
                       logic [FRM_TOT-1:0] frm);
        logic        f_p, f_v, e_und, e_gp;
        logic [31:0] reb;
        @(negedge clk);
        req_valid = 1'b1; cur_status = cur; saved_status = sv;
        saved_ip = ip; seg_base = base; seg16 = s16; frame_in = frm;
        @(negedge clk);
        req_valid = 1'b0;
        f_p = (cur[11:10] != 2'd0);
        f_v = !f_p && cur[9];
        e_und = 1'b0; e_gp = 1'b0;
        reb = ip[31:0] - base;
        if (!f_p && !f_v) begin
            if (sv[8]) begin
                e_live = {sv[11:4], 4'b0000};
                e_ip   = {{(IP_W-32){1'b0}}, reb};
                e_frm  = '0;
                e_und  = !sv[7] || !sv[6] || sv[5] || !sv[4];
                e_gp   = s16 && (reb >= 32'(1 << WIN_W));
            end else begin
                e_live = sv; e_ip = ip; e_frm = frm;
            end
        end
        chk("R4 done", 64'(done), 64'd1);
        chk("R1 fault_priv", 64'(fault_priv), 64'(f_p));
        chk("R2 fault_virt", 64'(fault_virt), 64'(f_v));
        chk("R3/R10 live_status", 64'(live_status), 64'(e_live));
        chk("R5/R7 ip_out", 64'(ip_out), 64'(e_ip));
        chk("R5/R8 frame_out", 64'(frame_out), 64'(e_frm));
        chk("R6 undef_flag", 64'(undef_flag), 64'(e_und));
        chk("R9 gp_fault", 64'(gp_fault), 64'(e_gp));
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 done", 64'(done), 64'd0);
        chk("R11 flags", 64'({fault_priv, fault_virt, undef_flag, gp_fault}), 64'd0);
        chk("R11 live_status", 64'(live_status), 64'd0);
        chk("R11 ip_out", 64'(ip_out), 64'd0);
        chk("R11 frame_out", 64'(frame_out), 64'd0);

        // Sweep every saved-status encoding
        for (int i = 0; i < 4096; i++) begin
            logic [ST_W-1:0]    cur;
            logic [31:0]        base;
            logic [IP_W-1:0]    ip;
            logic [FRM_TOT-1:0] frm;
            int sel;
            sel = i % 5;
            if (sel == 0)
                cur = {2'(((i / 5) % 3) + 1), 1'(i[3]), 9'(i)};
            else if (sel == 1)
                cur = {2'b00, 1'b1, 9'(i * 3)};
            else
                cur = {2'b00, 1'b0, 9'(i * 5)};
            base = 32'h1000 * 32'(i % 13);
            ip   = {4'(i), base + 32'((i * 7) % 600)};
            frm  = {7'(i), 7'(i + 1), 7'(i + 2), 7'(i * 3), 7'(i * 5), 7'(i + 9)};
            run(cur, 12'(i), ip, base, i[1], frm);
        end

        // R9 window boundary, legal legacy status, base near top of space
        for (int k = 0; k < 6; k++) begin
            logic [31:0] off;
            off = (k < 4) ? 32'(254 + k) : ((k == 4) ? 32'hFFFF_FFFF : 32'd0);
            run(12'h000, 12'h1DF, {4'hA, 32'hFFFF_FF80 + off}, 32'hFFFF_FF80, 1'b1,
                {FRM_TOT{1'b1}});
        end
        // R9 seg16 low: far pointer gives no fault
        run(12'h000, 12'h1DF, {4'h3, 32'h0012_3456}, 32'h0000_0010, 1'b0, '0);
        // R5 native after legacy: pointer upper bits pass through
        run(12'h000, 12'h0FF, {4'hF, 32'hDEAD_BEEF}, 32'h1234_5678, 1'b1,
            {6{7'h55}});
        // R1 fault then state unchanged
        run(12'hC00, 12'h1DF, 36'h0, 32'h0, 1'b1, '0);

        @(negedge clk);
        chk("R4 done idle", 64'(done), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule